// File: doc/BRIEF.md
# Toggle-Flag Bus Crossing With Returned Acknowledge

This block moves one multi-bit word at a time from a source clock domain into an unrelated destination clock domain. The word's bits never pass through synchronizers. The source captures the word into a holding register and inverts a single request bit. Only that bit travels through a flop chain clocked by the destination. The destination sees the request bit differ from its own stored copy, samples the held word, and updates its copy. That copy is the acknowledge bit, and it travels back through a second flop chain into the source domain.

A new word is accepted only when the returned acknowledge matches the request bit. This closed loop means the held word cannot change while the destination may still be sampling it. Each bit crossing the boundary is a level that stays put until the far side has answered. Transfers therefore arrive correctly at any ratio between the two clocks, including ratios close to one, where a pulse-based scheme tends to lose events.

The source side uses a valid/ready handshake. The destination side emits a single-cycle valid strobe together with the word.

Top module: `hsync_bus_xfer`

## Requirements
- R1: With both domains in reset and right after reset, `src_ready` is 1, `dst_valid` is 0 and `dst_data` is all zeros.
- R2: A word accepted on a source edge where `src_valid` and `src_ready` are both 1 later appears unchanged on `dst_data` while `dst_valid` is 1.
- R3: Every accepted word is delivered exactly once, and words come out in acceptance order. No strobe occurs without a matching acceptance.
- R4: `dst_valid` stays high for exactly one destination cycle per delivered word. Two strobes are never back to back.
- R5: `src_ready` is low in the source cycle after an acceptance. It stays low until the acknowledge has come back. The returned acknowledge changes only while a transfer is outstanding.
- R6: `src_valid` asserted while `src_ready` is low is ignored, and the word offered at that time is never delivered.
- R7: While a transfer is in flight, changes on `src_data` do not affect the delivered word. Between strobes, `dst_data` holds its last value.
- R8: R2 to R4 hold when the source clock is faster than, slower than, equal to, or only slightly different from the destination clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source may accept a word this cycle |
| src_data | input | WIDTH | Offered word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid | output | 1 | One-cycle strobe marking a delivered word |
| dst_data | output | WIDTH | Delivered word, held between strobes |

## Verification
The bench drives the source clock at several periods against a fixed destination clock, including one period only about one percent away from the destination's, where the phases slowly slide past each other. While a transfer is in flight, it keeps offering marked junk words with `src_valid` toggling. A design that accepted while busy, or that let the holding register follow the bus, would deliver a marked word or a corrupted one. A receiver that compared against the raw request bit instead of its stored copy would strobe for more than one cycle or deliver the same word twice. A source that released ready before the acknowledge returned would overwrite a word before it was sampled, which shows up as lost or out-of-order words in the scoreboard.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    localparam int unsigned HS_MIN_STAGES = 2;

    // Two toggle levels disagree: a transfer is outstanding.
    function automatic logic tgl_differ(input logic a, input logic b);
        return a ^ b;
    endfunction

    // Flop chains shorter than two stages give no settling margin.
    function automatic int unsigned chain_len(input int unsigned s);
        return (s < HS_MIN_STAGES) ? HS_MIN_STAGES : s;
    endfunction

endpackage

// File: rtl/hs_sync_flag.sv
module hs_sync_flag #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    import hsync_pkg::*;
    localparam int unsigned LEN = chain_len(STAGES);

    logic [LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LEN-2:0], d_async};
    end

    assign q = chain[LEN-1];
endmodule

// File: rtl/hs_src.sv
module hs_src #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [WIDTH-1:0] data,
    input  logic             ack_async,
    output logic             ready,
    output logic             req_tgl,
    output logic [WIDTH-1:0] hold
);
    import hsync_pkg::*;

    logic ack_s;
    logic accept;

    hs_sync_flag #(.STAGES(STAGES)) u_ack_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ack_async),
        .q       (ack_s)
    );

    assign ready  = ~tgl_differ(req_tgl, ack_s);
    assign accept = valid & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            hold    <= '0;
        end else if (accept) begin
            req_tgl <= ~req_tgl;
            hold    <= data;
        end
    end

    // R5: ready must fall right after an acceptance (acknowledge path is slow)
    a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !ready);

    // R5: the returned acknowledge only moves while a transfer is outstanding
    a_r5_ack_only_when_pending: assert property (@(posedge clk) disable iff (rst)
        (ack_s != $past(ack_s)) |-> ($past(req_tgl) != $past(ack_s)));
endmodule

// File: rtl/hs_dst.sv
module hs_dst #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_async,
    input  logic [WIDTH-1:0] bus_async,
    output logic             valid,
    output logic [WIDTH-1:0] data,
    output logic             ack_tgl
);
    import hsync_pkg::*;

    logic req_s;
    logic seen;
    logic change;

    hs_sync_flag #(.STAGES(STAGES)) u_req_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (req_async),
        .q       (req_s)
    );

    assign change = tgl_differ(req_s, seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= change;
            if (change) begin
                seen <= req_s;
                data <= bus_async;
            end
        end
    end

    assign ack_tgl = seen;

    // R4: a delivery strobe never lasts two cycles
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7: the delivered word holds between strobes
    a_r7_data_held: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(data));
endmodule

// File: rtl/hsync_bus_xfer.sv
module hsync_bus_xfer #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst,
    input  logic             src_valid,
    output logic             src_ready,
    input  logic [WIDTH-1:0] src_data,
    input  logic             dst_clk,
    input  logic             dst_rst,
    output logic             dst_valid,
    output logic [WIDTH-1:0] dst_data
);
    logic             req_tgl;
    logic             ack_tgl;
    logic [WIDTH-1:0] hold;

    hs_src #(.WIDTH(WIDTH), .STAGES(STAGES)) u_src (
        .clk       (src_clk),
        .rst       (src_rst),
        .valid     (src_valid),
        .data      (src_data),
        .ack_async (ack_tgl),
        .ready     (src_ready),
        .req_tgl   (req_tgl),
        .hold      (hold)
    );

    hs_dst #(.WIDTH(WIDTH), .STAGES(STAGES)) u_dst (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_async (req_tgl),
        .bus_async (hold),
        .valid     (dst_valid),
        .data      (dst_data),
        .ack_tgl   (ack_tgl)
    );
endmodule

// File: tb/hsync_bus_xfer_tb.sv
`timescale 1ns/1ps
module hsync_bus_xfer_tb;
    localparam int W = 12;
    localparam int N_PER_PHASE = 60;

    logic src_clk = 0, dst_clk = 0;
    logic src_rst = 1, dst_rst = 1;
    logic src_valid = 0;
    logic [W-1:0] src_data = '0;
    logic src_ready, dst_valid;
    logic [W-1:0] dst_data;

    realtime src_half = 4.0;
    always #(src_half) src_clk = ~src_clk;
    always #4.0 dst_clk = ~dst_clk;   // 125 MHz destination

    hsync_bus_xfer #(.WIDTH(W), .STAGES(2)) u_dut (
        .src_clk(src_clk), .src_rst(src_rst), .src_valid(src_valid),
        .src_ready(src_ready), .src_data(src_data),
        .dst_clk(dst_clk), .dst_rst(dst_rst),
        .dst_valid(dst_valid), .dst_data(dst_data)
    );

    int tests = 0, fails = 0;
    int wr = 0, rd = 0;
    logic [W-1:0] exp_q [0:511];
    logic prev_valid = 0;
    bit done = 0;

    task automatic fail(input string req, input int act, input int expv);
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    endtask

    // Monitor: scoreboard on destination side
    always @(negedge dst_clk) begin
        if (!dst_rst) begin
            if (dst_valid) begin
                tests++;
                if (prev_valid) fail("R4 back-to-back strobe", 1, 0);
                if (dst_data[W-1]) fail("R6 busy offer delivered", dst_data, 0);
                else if (rd >= wr) fail("R3 extra delivery", rd, wr);
                else if (dst_data !== exp_q[rd]) fail("R2/R7 word mismatch", dst_data, exp_q[rd]);
                rd++;
            end
            prev_valid <= dst_valid;
        end
    end

    task automatic send(input int i, input logic [W-1:0] val);
        int k = 0;
        @(negedge src_clk);
        while (!src_ready) begin
            src_valid = k[0];
            src_data  = 12'h800 | W'((i * 53 + k * 7) & 12'h7FF);   // R6/R7 junk while busy
            k++;
            @(negedge src_clk);
        end
        src_valid = 1;
        src_data  = val;
        exp_q[wr] = val;
        wr++;
        @(posedge src_clk);
        @(negedge src_clk);
        tests++;
        if (src_ready !== 1'b0) fail("R5 ready after accept", src_ready, 0);
        src_valid = 0;
        src_data  = 12'h800 | W'(i & 12'h7FF);
        if (i % 3 == 0) repeat (2) @(negedge src_clk);
    endtask

    initial begin
        realtime halves [4] = '{4.0, 1.5, 13.0, 4.05};
        repeat (4) @(negedge dst_clk);
        tests++;   // R1 during reset
        if (src_ready !== 1'b1 || dst_valid !== 1'b0 || dst_data !== '0)
            fail("R1 reset state", {src_ready, dst_valid}, 2);
        @(negedge src_clk); src_rst = 0;
        @(negedge dst_clk); dst_rst = 0;
        @(negedge dst_clk);
        tests++;   // R1 after reset
        if (src_ready !== 1'b1 || dst_valid !== 1'b0 || dst_data !== '0)
            fail("R1 after reset", {src_ready, dst_valid}, 2);

        for (int p = 0; p < 4; p++) begin
            src_half = halves[p];
            for (int i = 0; i < N_PER_PHASE; i++)
                send(i, W'((i * 37 + p * 101 + 5) & 12'h7FF));
            while (rd < wr) @(negedge dst_clk);
            repeat (10) @(negedge dst_clk);
            tests++;   // R8 phase complete at this clock ratio
            if (rd != wr) fail("R8 phase count", rd, wr);
        end

        repeat (40) @(negedge dst_clk);
        tests++;   // R3 exactly once overall
        if (rd != 4 * N_PER_PHASE) fail("R3 total deliveries", rd, 4 * N_PER_PHASE);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            tests++;
            fail("watchdog", rd, wr);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule